// File: doc/BRIEF.md
# Programmable Single-Channel DMA Engine

This block is one data-movement channel that software sets up through a small register bank and then lets run on its own. Software writes a source base, a destination base, a count and a control word. The channel then copies data one beat at a time over a master port that has separate read and write phases. Each beat reads one item from the current source and writes it to the current destination. The item is 8, 16 or 32 bits wide. Each address can step up, step down or stay fixed. When the count runs out, the channel drops its enable, sets a sticky terminal-count flag and can raise an interrupt.

A transfer is started by software or paced by an external request line. In the external case, each beat is answered with a one-cycle acknowledge pulse. Software chooses the polarity of both the request and the acknowledge. A base address that does not suit the chosen width is reported in two read-only error bits, and no transfer can start while either bit is set. The register map, byte offsets on a 5-bit address:

- 0x00 control
- 0x04 source base
- 0x08 destination base
- 0x0C count
- 0x10 current source (read-only)
- 0x14 current destination (read-only)
- 0x18 current count (read-only)

Top module: `dma_chan`

## Requirements
- R1: After reset, control reads 0, `irq_o` is 0, `rd_valid` and `wr_valid` are 0, and `ext_ack` is 1, which is the inactive level for the default active-low acknowledge.
- R2: The bases and the count read back what was written. A write to the read-only current registers at 0x10, 0x14 and 0x18 changes nothing. Read data appears one cycle after `reg_rd`.
- R3: A write with control bit0 (enable) set starts a software transfer only if bit16 (software request) is set in the same write. Without bit16, and without external mode (bit2), the write is ignored: enable reads 0 and no read beat is issued.
- R4: Each beat has two phases. The read handshake at the current source completes first. Then a write of that same data is issued to the current destination. Both phases carry the width code (control bits 13:12) on `xfer_size`.
- R5: After each beat, an address steps by the width in bytes: 1, 2 or 4 for codes 0, 1 and 2. It steps down instead of up when its decrement bit is set (bit5 source, bit4 destination). It does not change at all when its fixed bit is set (bit7 source, bit6 destination).
- R6: The count is in units. One unit is one beat, or four beats when burst mode (bit9) is set. The current count decreases by one per finished unit.
- R7: When the count reaches zero, control bit18 (terminal count) is set and bit0 clears by itself. `irq_o` equals terminal count AND interrupt enable (bit8).
- R8: Writing control with bit18 = 0 clears terminal count. Writing it with bit18 = 1 leaves it unchanged.
- R9: Bit22 flags a misaligned source base and bit21 a misaligned destination base. A 16-bit width is misaligned when address bit0 is set. A 32-bit width is misaligned when bits 1:0 are nonzero. While either flag is set, enable cannot be set.
- R10: When enable goes from 0 to 1, the current source, destination and count registers reload from the base registers.
- R11: In external mode (bit2), beats wait for an active request. The request is active-low unless bit25 is set. Each beat gives one `ext_ack` pulse of one cycle, active-low unless bit24 is set.
- R12: In external mode with demand (bit15), units continue while the request stays active. Without demand, each new assertion of the request grants exactly one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_addr | output | AW | Read address |
| rd_data | input | DW | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| xfer_size | output | 2 | Beat width code for both phases |
| ext_req | input | 1 | External transfer request, programmable polarity |
| ext_ack | output | 1 | Per-beat acknowledge, programmable polarity |
| irq_o | output | 1 | Completion interrupt |

## Verification
A corrupted current pointer would be seen on the very next beat, as a wrong `wr_addr` or as data that does not match the bench's address pattern. A corrupted current count would be seen at completion, as too many or too few logged writes, or as an interrupt that comes early or never comes. A stuck pending-request or beat-position state would show as an extra or missing write and acknowledge pulse within a single unit. A wrong enable or terminal-count state would be visible at the next control read.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_W = 32;

  // control bit positions, decoded by software
  localparam int B_EN     = 0;
  localparam int B_EXT    = 2;
  localparam int B_DDEC   = 4;
  localparam int B_SDEC   = 5;
  localparam int B_DFIX   = 6;
  localparam int B_SFIX   = 7;
  localparam int B_IEN    = 8;
  localparam int B_BURST  = 9;
  localparam int B_WLO    = 12;
  localparam int B_DEMAND = 15;
  localparam int B_SWREQ  = 16;
  localparam int B_TC     = 18;
  localparam int B_DERR   = 21;
  localparam int B_SERR   = 22;
  localparam int B_ACKHI  = 24;
  localparam int B_REQHI  = 25;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READ = 2'd1, ST_WRITE = 2'd2} eng_state_t;

  function automatic logic misaligned(input logic [1:0] a, input logic [1:0] w);
    return (w == 2'd1 && a[0]) || (w == 2'd2 && a != 2'd0);
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs import dma_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              done,
  input  logic [AW-1:0]     cur_src,
  input  logic [AW-1:0]     cur_dst,
  input  logic [CW-1:0]     cur_cnt,
  output logic              en,
  output logic              arm,
  output logic              irq,
  output logic              ext_mode,
  output logic              demand,
  output logic              burst,
  output logic              sdec,
  output logic              ddec,
  output logic              sfix,
  output logic              dfix,
  output logic              req_hi,
  output logic              ack_hi,
  output logic [1:0]        width,
  output logic [AW-1:0]     src_base,
  output logic [AW-1:0]     dst_base,
  output logic [CW-1:0]     cnt_base
);
  localparam logic [REG_W-1:0] STORE_MASK =
    (REG_W'(1) << B_EXT)   | (REG_W'(1) << B_DDEC)   | (REG_W'(1) << B_SDEC)  |
    (REG_W'(1) << B_DFIX)  | (REG_W'(1) << B_SFIX)   | (REG_W'(1) << B_IEN)   |
    (REG_W'(1) << B_BURST) | (REG_W'(3) << B_WLO)    | (REG_W'(1) << B_DEMAND)|
    (REG_W'(1) << B_ACKHI) | (REG_W'(1) << B_REQHI);

  logic [REG_W-1:0] ctrl_q;
  logic             tc_q;
  logic             serr, derr, serr_new, derr_new;
  logic [1:0]       w_new;
  logic [REG_W-1:0] ctrl_view;
  logic             ctrl_wr;

  assign ctrl_wr  = reg_wr && reg_addr == 5'h00;
  assign w_new    = ctrl_wr ? reg_wdata[B_WLO +: 2] : ctrl_q[B_WLO +: 2];
  assign serr_new = misaligned(src_base[1:0], w_new);
  assign derr_new = misaligned(dst_base[1:0], w_new);
  assign serr     = misaligned(src_base[1:0], ctrl_q[B_WLO +: 2]);
  assign derr     = misaligned(dst_base[1:0], ctrl_q[B_WLO +: 2]);

  // rising enable: needs aligned bases and a start source in the same write
  assign arm = ctrl_wr && reg_wdata[B_EN] && !en && !serr_new && !derr_new &&
               (reg_wdata[B_EXT] || reg_wdata[B_SWREQ]);

  assign ext_mode = ctrl_q[B_EXT];
  assign demand   = ctrl_q[B_DEMAND];
  assign burst    = ctrl_q[B_BURST];
  assign sdec     = ctrl_q[B_SDEC];
  assign ddec     = ctrl_q[B_DDEC];
  assign sfix     = ctrl_q[B_SFIX];
  assign dfix     = ctrl_q[B_DFIX];
  assign req_hi   = ctrl_q[B_REQHI];
  assign ack_hi   = ctrl_q[B_ACKHI];
  assign width    = ctrl_q[B_WLO +: 2];
  assign irq      = tc_q && ctrl_q[B_IEN];

  always_comb begin
    ctrl_view         = ctrl_q;
    ctrl_view[B_EN]   = en;
    ctrl_view[B_TC]   = tc_q;
    ctrl_view[B_SERR] = serr;
    ctrl_view[B_DERR] = derr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      en        <= 1'b0;
      tc_q      <= 1'b0;
      src_base  <= '0;
      dst_base  <= '0;
      cnt_base  <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          5'h00:   ctrl_q   <= reg_wdata & STORE_MASK;
          5'h04:   src_base <= AW'(reg_wdata);
          5'h08:   dst_base <= AW'(reg_wdata);
          5'h0C:   cnt_base <= CW'(reg_wdata);
          default: ;
        endcase
      end
      if (done)         en <= 1'b0;
      else if (ctrl_wr) en <= reg_wdata[B_EN] && (en || arm);
      if (done)                              tc_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata[B_TC])  tc_q <= 1'b0;
      if (reg_rd) begin
        case (reg_addr)
          5'h00:   reg_rdata <= ctrl_view;
          5'h04:   reg_rdata <= REG_W'(src_base);
          5'h08:   reg_rdata <= REG_W'(dst_base);
          5'h0C:   reg_rdata <= REG_W'(cnt_base);
          5'h10:   reg_rdata <= REG_W'(cur_src);
          5'h14:   reg_rdata <= REG_W'(cur_dst);
          5'h18:   reg_rdata <= REG_W'(cur_cnt);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
    tc_q && !(ctrl_wr && !reg_wdata[B_TC]) |=> tc_q); // R8
  AST_NO_LONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && reg_wdata[B_EN] && !reg_wdata[B_SWREQ] && !reg_wdata[B_EXT] && !en |=> !en); // R3
  AST_ALIGNED_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> !serr && !derr); // R9
endmodule

// File: rtl/dma_reqif.sv
module dma_reqif (
  input  logic clk,
  input  logic rst,
  input  logic ext_req,
  input  logic req_hi,
  input  logic ack_hi,
  input  logic arm,
  input  logic grant,
  input  logic beat_ack,
  output logic req_active,
  output logic req_pend,
  output logic ext_ack
);
  logic req_q, act_d, ack_q;

  assign req_active = req_hi ? req_q : !req_q;
  assign ext_ack    = ack_hi ? ack_q : !ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b1;
      act_d    <= 1'b0;
      req_pend <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      req_q <= ext_req;
      act_d <= req_active;
      ack_q <= beat_ack;
      if (arm) req_pend <= 1'b0;
      else     req_pend <= (req_active && !act_d) || (req_pend && !grant);
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q); // R11
endmodule

// File: rtl/dma_engine.sv
module dma_engine import dma_pkg::*; #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          arm,
  input  logic          ext_mode,
  input  logic          demand,
  input  logic          burst,
  input  logic          sdec,
  input  logic          ddec,
  input  logic          sfix,
  input  logic          dfix,
  input  logic [1:0]    width,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] cnt_base,
  input  logic          req_active,
  input  logic          req_pend,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt,
  output logic          grant,
  output logic          done,
  output logic          beat_ack
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  eng_state_t        st;
  logic [BEAT_W-1:0] beat;
  logic              unit_ok, last_beat, wr_fire;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input logic fix,
                                               input logic dec, input logic [1:0] w);
    logic [AW-1:0] d;
    d = (w == 2'd2) ? AW'(4) : (w == 2'd1) ? AW'(2) : AW'(1);
    if (fix) return a;
    return dec ? a - d : a + d;
  endfunction

  assign unit_ok   = ext_mode ? (demand ? req_active : req_pend) : 1'b1;
  assign last_beat = !burst || beat == BEAT_W'(BURST_LEN - 1);
  assign wr_fire   = st == ST_WRITE && wr_ready;
  assign grant     = st == ST_IDLE && en && !arm && cur_cnt != '0 && unit_ok;
  assign done      = (st == ST_IDLE && en && !arm && cur_cnt == '0) ||
                     (wr_fire && last_beat && cur_cnt == CW'(1));
  assign beat_ack  = wr_fire && ext_mode;
  assign rd_valid  = st == ST_READ;
  assign wr_valid  = st == ST_WRITE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      beat    <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
      wr_data <= '0;
    end else if (arm) begin
      st      <= ST_IDLE;
      beat    <= '0;
      cur_src <= src_base;
      cur_dst <= dst_base;
      cur_cnt <= cnt_base;
    end else begin
      case (st)
        ST_IDLE: if (grant) begin
          st   <= ST_READ;
          beat <= '0;
        end
        ST_READ: if (rd_ready) begin
          wr_data <= rd_data;
          st      <= ST_WRITE;
        end
        ST_WRITE: if (wr_ready) begin
          cur_src <= next_addr(cur_src, sfix, sdec, width);
          cur_dst <= next_addr(cur_dst, dfix, ddec, width);
          if (last_beat) begin
            cur_cnt <= cur_cnt - CW'(1);
            st      <= ST_IDLE;
          end else begin
            beat <= beat + BEAT_W'(1);
            st   <= ST_READ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> $past(rd_valid && rd_ready)); // R4
  AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready && !arm |=> rd_valid && $stable(cur_src)); // R4
  AST_COUNT_DOWN_ONLY: assert property (@(posedge clk) disable iff (rst)
    !arm |=> cur_cnt <= $past(cur_cnt)); // R6
  AST_BEAT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> $past(en)); // R3
endmodule

// File: rtl/dma_chan.sv
module dma_chan import dma_pkg::*; #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [4:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic [1:0]       xfer_size,
  input  logic             ext_req,
  output logic             ext_ack,
  output logic             irq_o
);
  logic          en, arm, ext_mode, demand, burst, sdec, ddec, sfix, dfix, req_hi, ack_hi;
  logic [1:0]    width;
  logic [AW-1:0] src_base, dst_base, cur_src, cur_dst;
  logic [CW-1:0] cnt_base, cur_cnt;
  logic          done, grant, beat_ack, req_active, req_pend;

  assign rd_addr   = cur_src;
  assign wr_addr   = cur_dst;
  assign xfer_size = width;

  dma_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
    .en(en), .arm(arm), .irq(irq_o), .ext_mode(ext_mode), .demand(demand),
    .burst(burst), .sdec(sdec), .ddec(ddec), .sfix(sfix), .dfix(dfix),
    .req_hi(req_hi), .ack_hi(ack_hi), .width(width),
    .src_base(src_base), .dst_base(dst_base), .cnt_base(cnt_base));

  dma_reqif reqif_i (
    .clk(clk), .rst(rst), .ext_req(ext_req), .req_hi(req_hi), .ack_hi(ack_hi),
    .arm(arm), .grant(grant), .beat_ack(beat_ack),
    .req_active(req_active), .req_pend(req_pend), .ext_ack(ext_ack));

  dma_engine #(.AW(AW), .DW(DW), .CW(CW), .BURST_LEN(BURST_LEN)) eng_i (
    .clk(clk), .rst(rst), .en(en), .arm(arm), .ext_mode(ext_mode), .demand(demand),
    .burst(burst), .sdec(sdec), .ddec(ddec), .sfix(sfix), .dfix(dfix), .width(width),
    .src_base(src_base), .dst_base(dst_base), .cnt_base(cnt_base),
    .req_active(req_active), .req_pend(req_pend),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
    .grant(grant), .done(done), .beat_ack(beat_ack));
endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb_top;
  localparam int CLK_NS = 10;
  localparam logic [31:0] EN = 32'h1, EXT = 32'h1 << 2, DDEC = 32'h1 << 4, SDEC = 32'h1 << 5;
  localparam logic [31:0] DFIX = 32'h1 << 6, IEN = 32'h1 << 8, BURST = 32'h1 << 9;
  localparam logic [31:0] W16 = 32'h1 << 12, W32 = 32'h2 << 12, DEMAND = 32'h1 << 15;
  localparam logic [31:0] SWREQ = 32'h1 << 16, TC = 32'h1 << 18, DERR = 32'h1 << 21;
  localparam logic [31:0] SERR = 32'h1 << 22, ACKHI = 32'h1 << 24, REQHI = 32'h1 << 25;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rd_valid, wr_valid, rd_ready = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_addr, wr_addr, wr_data, rd_data = '0;
  logic [1:0] xfer_size;
  logic ext_req = 1'b1, ext_ack, irq_o;

  always #(CLK_NS / 2) clk = ~clk;

  dma_chan dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .xfer_size(xfer_size), .ext_req(ext_req),
    .ext_ack(ext_ack), .irq_o(irq_o));

  int n_chk = 0, n_err = 0, n_wr = 0, n_ack = 0, cyc = 0;
  logic stall = 1'b0, ack_lvl = 1'b0;
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  logic [1:0]  log_size [16];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  // memory responder: drives ready/data, logs write handshakes of the next edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rd_ready = !stall || (cyc % 3 != 0);
      wr_ready = !stall || (cyc % 2 != 0);
      rd_data  = pat(rd_addr);
      if (wr_valid && wr_ready) begin
        if (n_wr < 16) begin
          log_addr[n_wr] = wr_addr;
          log_data[n_wr] = wr_data;
          log_size[n_wr] = xfer_size;
        end
        n_wr++;
      end
      if (!rst && ext_ack == ack_lvl) n_ack++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr_reg(5'h04, s);
    wr_reg(5'h08, d);
    wr_reg(5'h0C, c);
    n_wr = 0;
  endtask

  task automatic wait_irq(input string req);
    for (int i = 0; i < 2000 && !irq_o; i++) @(negedge clk);
    check(req, "irq after count end", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1", "wr_valid", {31'd0, wr_valid}, 32'd0);
    check("R1", "irq", {31'd0, irq_o}, 32'd0);
    check("R1", "ext_ack idle", {31'd0, ext_ack}, 32'd1);
    rd_reg(5'h00, v);
    check("R1", "control", v, 32'd0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    setup(32'h0000_1234, 32'hCAFE_0000, 32'h55);
    rd_reg(5'h04, v); check("R2", "source base", v, 32'h0000_1234);
    rd_reg(5'h08, v); check("R2", "dest base", v, 32'hCAFE_0000);
    rd_reg(5'h0C, v); check("R2", "count", v, 32'h55);
    wr_reg(5'h10, 32'hFFFF_FFFF);
    wr_reg(5'h18, 32'h0000_FFFF);
    rd_reg(5'h10, v); check("R2", "cur source after write", v, 32'd0);
    rd_reg(5'h18, v); check("R2", "cur count after write", v, 32'd0);
  endtask

  task automatic t_nostart();
    logic [31:0] v;
    setup(32'h1000, 32'h2000, 3);
    wr_reg(5'h00, EN | W32);
    repeat (8) @(negedge clk);
    rd_reg(5'h00, v); check("R3", "enable without request", v, W32);
    check("R3", "no beats", n_wr, 0);
    rd_reg(5'h10, v); check("R10", "no reload without start", v, 32'd0);
    wr_reg(5'h00, 32'd0);
  endtask

  task automatic t_sw32();
    logic [31:0] v;
    stall = 1'b1;
    setup(32'h1000, 32'h2000, 3);
    wr_reg(5'h00, EN | SWREQ | IEN | W32);
    wait_irq("R7");
    check("R6", "beat count", n_wr, 3);
    for (int i = 0; i < 3; i++) begin
      check("R5", "wr_addr inc 4", log_addr[i], 32'h2000 + 4 * i);
      check("R4", "data copied", log_data[i], pat(32'h1000 + 4 * i));
      check("R4", "size code", {30'd0, log_size[i]}, 32'd2);
    end
    rd_reg(5'h00, v); check("R7", "tc set, enable clear", v, IEN | W32 | TC);
    rd_reg(5'h10, v); check("R5", "final source", v, 32'h100C);
    rd_reg(5'h14, v); check("R5", "final dest", v, 32'h200C);
    rd_reg(5'h18, v); check("R7", "final count", v, 32'd0);
    stall = 1'b0;
  endtask

  task automatic t_tcclear();
    logic [31:0] v;
    wr_reg(5'h00, TC | IEN | W32);
    rd_reg(5'h00, v); check("R8", "write 1 keeps tc", v, IEN | W32 | TC);
    check("R8", "irq kept", {31'd0, irq_o}, 32'd1);
    wr_reg(5'h00, IEN | W32);
    rd_reg(5'h00, v); check("R8", "write 0 clears tc", v, IEN | W32);
    check("R7", "irq follows tc", {31'd0, irq_o}, 32'd0);
    wr_reg(5'h00, 32'd0);
  endtask

  task automatic t_dec_fix();
    logic [31:0] v;
    setup(32'h3010, 32'h4000, 3);
    wr_reg(5'h00, EN | SWREQ | IEN | W16 | SDEC | DFIX);
    wait_irq("R7");
    check("R6", "beat count", n_wr, 3);
    check("R10", "first read from reloaded base", log_data[0], pat(32'h3010));
    for (int i = 0; i < 3; i++) begin
      check("R5", "fixed dest", log_addr[i], 32'h4000);
      check("R5", "source dec 2", log_data[i], pat(32'h3010 - 2 * i));
    end
    rd_reg(5'h10, v); check("R5", "final source", v, 32'h300A);
    wr_reg(5'h00, 32'd0);
  endtask

  task automatic t_burst();
    logic [31:0] v;
    stall = 1'b1;
    setup(32'h500, 32'h607, 2);
    wr_reg(5'h00, EN | SWREQ | IEN | BURST | DDEC);
    wait_irq("R7");
    check("R6", "burst beats", n_wr, 8);
    for (int i = 0; i < 8; i++) begin
      check("R5", "dest dec 1", log_addr[i], 32'h607 - i);
      check("R5", "source inc 1", log_data[i], pat(32'h500 + i));
    end
    rd_reg(5'h10, v); check("R6", "final source", v, 32'h508);
    rd_reg(5'h14, v); check("R5", "final dest", v, 32'h5FF);
    rd_reg(5'h18, v); check("R6", "final units", v, 32'd0);
    wr_reg(5'h00, 32'd0);
    stall = 1'b0;
  endtask

  task automatic t_bound();
    logic [31:0] v;
    setup(32'h1002, 32'h2001, 2);
    wr_reg(5'h00, W16);
    rd_reg(5'h00, v); check("R9", "16-bit flags", v, W16 | DERR);
    wr_reg(5'h00, W32);
    rd_reg(5'h00, v); check("R9", "32-bit flags", v, W32 | SERR | DERR);
    wr_reg(5'h00, EN | SWREQ | W32);
    repeat (8) @(negedge clk);
    rd_reg(5'h00, v); check("R9", "start refused", v, W32 | SERR | DERR);
    check("R9", "no beats", n_wr, 0);
    wr_reg(5'h00, 32'd0);
    rd_reg(5'h00, v); check("R9", "8-bit no flags", v, 32'd0);
  endtask

  task automatic t_ext_pulse();
    ack_lvl = 1'b0;
    ext_req = 1'b1;
    setup(32'h800, 32'h900, 2);
    wr_reg(5'h00, EN | EXT | IEN | W32);
    @(negedge clk); n_ack = 0;
    repeat (6) @(negedge clk);
    check("R11", "no beat without request", n_wr, 0);
    check("R11", "ack idle high", {31'd0, ext_ack}, 32'd1);
    ext_req = 1'b0;
    repeat (20) @(negedge clk);
    check("R12", "one unit per assertion", n_wr, 1);
    check("R11", "one ack pulse", n_ack, 1);
    ext_req = 1'b1;
    repeat (4) @(negedge clk);
    ext_req = 1'b0;
    wait_irq("R7");
    check("R12", "second assertion second unit", n_wr, 2);
    check("R11", "ack pulses", n_ack, 2);
    check("R4", "ext write addr", log_addr[1], 32'h904);
    ext_req = 1'b1;
    wr_reg(5'h00, 32'd0);
  endtask

  task automatic t_ext_demand();
    ack_lvl = 1'b1;
    ext_req = 1'b0;
    setup(32'hA00, 32'hB00, 4);
    wr_reg(5'h00, EN | EXT | DEMAND | REQHI | ACKHI | IEN | W32);
    @(negedge clk); n_ack = 0;
    repeat (6) @(negedge clk);
    check("R11", "no beat, request low", n_wr, 0);
    check("R11", "ack idle low", {31'd0, ext_ack}, 32'd0);
    ext_req = 1'b1;
    wait_irq("R7");
    check("R12", "demand runs all units", n_wr, 4);
    check("R11", "ack per beat", n_ack, 4);
    check("R4", "last data", log_data[3], pat(32'hA0C));
    ext_req = 1'b0;
    wr_reg(5'h00, 32'd0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_nostart();
    t_sw32();
    t_tcclear();
    t_dec_fix();
    t_burst();
    t_bound();
    t_ext_pulse();
    t_ext_demand();
    report();
    $finish;
  end
endmodule